// File: doc/BRIEF.md
# Three-Channel Shared-Period PWM

This block drives three pulse-width modulated outputs from one shared period counter. Software programs one 14-bit period value and a 14-bit duty value for each channel through a simple register write and read port. The shared counter steps on a clock-enable strobe, which lets the integration choose the PWM time base without a second clock. Each output is high while the counter is below that channel's duty value.

A control register enables the three channels as a group. It also holds a software pause and a permission bit that lets a hardware hold input freeze the channels. While paused, the counter and the outputs keep their values. Period and duty writes are staged and only applied when the counter wraps, so an output never shows a shortened or stretched period.

Top module: `pwm3_shared_period`

## Requirements
- R1: After reset the control register reads 4 (hardware hold permitted, disabled, not paused). The period and the three duty registers read 0, and all outputs are low.
- R2: Register addresses are 0 for control, 1 for period, and 2, 3 and 4 for the duty of channels 0, 1 and 2. In the control register, bit 0 is enable, bit 1 is software pause and bit 2 is hardware-hold permission. A read returns the last value written, truncated to the register width (3 bits for control, 14 bits for the others), with the upper bits read as zero.
- R3: While enabled and not paused, the counter advances by one on each cycle with the clock enable high. It does not move on other cycles. It counts from 0 up to the active period and then returns to 0.
- R4: Output i is high exactly while the counter is below channel i's active duty. A duty of 0 keeps the output low. A duty above the period keeps it high.
- R5: With the software pause bit set, the counter and all three outputs hold their values. Counting resumes from the held value when the bit is cleared.
- R6: With hardware-hold permission set, a high hold input pauses the channels in the same way as R5.
- R7: With hardware-hold permission clear, the hold input has no effect on the outputs.
- R8: With enable clear, the counter is held at 0 and all outputs are low.
- R9: A written period or duty value becomes active only when the counter wraps, or while the block is disabled. A value written in the middle of a period leaves that period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Clock enable that steps the shared counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| hw_hold | input | 1 | Hardware pause request |
| pwm_out | output | 3 | PWM outputs, bit i for channel i |

## Verification
The hardest case to reach is a staged value written in the middle of a period while a pause is in effect or while the clock enable strobes only sparsely. In that case the old duty must hold until the delayed wrap. The stimulus changes period and duty at arbitrary counter positions, under both dense and one-in-three clock-enable patterns, and applies pauses across wrap points. A cycle-accurate reference model in the bench queues the expected output word for every cycle, and a monitor compares each one after the clock edge.

// File: rtl/pwm3_pkg.sv
// Package: shared widths, register addresses and the control word layout
// for the three-channel shared-period PWM.
package pwm3_pkg;
    localparam int unsigned ADDR_CTRL   = 0;
    localparam int unsigned ADDR_PERIOD = 1;
    localparam int unsigned ADDR_DUTY0  = 2;

    typedef struct packed {
        logic hold_allow;  // bit 2: hardware hold input may pause
        logic sw_pause;    // bit 1: software pause
        logic enable;      // bit 0: channels enabled
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{hold_allow: 1'b1, sw_pause: 1'b0, enable: 1'b0};
endpackage

// File: rtl/pwm3_regs.sv
// Module: pwm3_regs
// Holds the control word and the staged period and duty values written
// through the register port. Reads are combinational.
// Assumes DATA_W > CNT_W and that the address space fits ADDR_W bits.
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 14,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output ctrl_t                         ctrl_o,
    output logic [CNT_W-1:0]              period_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]  duty_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_o <= CTRL_RESET;
        else if (wr_en && wr_addr == ADDR_W'(ADDR_CTRL))
            ctrl_o <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // Staged period register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_o <= '0;
        else if (wr_en && wr_addr == ADDR_W'(ADDR_PERIOD))
            period_o <= wr_data[CNT_W-1:0];
    end

    // One staged duty register per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_duty
        always_ff @(posedge clk) begin
            if (!rst_n)
                duty_o[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(ADDR_DUTY0 + g))
                duty_o[g] <= wr_data[CNT_W-1:0];
        end
    end

    // Read multiplexer, zero extended to the port width.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_CTRL))
            rd_data = DATA_W'(ctrl_o);
        else if (rd_addr == ADDR_W'(ADDR_PERIOD))
            rd_data = DATA_W'(period_o);
        for (int i = 0; i < NUM_CH; i++)
            if (rd_addr == ADDR_W'(ADDR_DUTY0 + i))
                rd_data = DATA_W'(duty_o[i]);
    end

    // R1: the control word leaves reset with only the hold permission set.
    p_ctrl_reset_r1: assert property (@(posedge clk)
        !rst_n |=> ctrl_o == CTRL_RESET);
endmodule

// File: rtl/pwm3_counter.sv
// Module: pwm3_counter
// Shared period counter. It counts 0..period on each enabled strobe, holds
// while paused and clears while disabled. It owns the active period copy and
// tells the channels when staged values may be loaded.
// Assumes pause_i is synchronous to clk.
module pwm3_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             pause_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] period_pend_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             load_o
);
    logic [CNT_W-1:0] period_act;
    logic             advance;
    logic             at_top;

    assign advance = enable_i && !pause_i && step_i;
    assign at_top  = cnt_o >= period_act;
    assign load_o  = !enable_i || (advance && at_top);

    // Counter and active period: clear when off, step or wrap when running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o      <= '0;
            period_act <= '0;
        end else if (!enable_i) begin
            cnt_o      <= '0;
            period_act <= period_pend_i;
        end else if (advance) begin
            if (at_top) begin
                cnt_o      <= '0;
                period_act <= period_pend_i;
            end else begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end

    // R3: the counter never passes the active period.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= period_act);
    // R3: without a strobe an enabled counter stays put.
    p_no_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !step_i) |=> $stable(cnt_o));
    // R5: a pause freezes the counter.
    p_pause_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && pause_i) |=> $stable(cnt_o));
    // R8: disabling returns the counter to zero.
    p_off_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> cnt_o == '0);
    // R9: the active period only changes at a counter origin.
    p_period_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(period_act) |-> cnt_o == '0);
endmodule

// File: rtl/pwm3_channel.sv
// Module: pwm3_channel
// One PWM comparator with its own active duty copy, which is refreshed from
// the staged value only when the counter module raises load_i.
module pwm3_channel #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] duty_pend_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             pwm_o
);
    logic [CNT_W-1:0] duty_act;

    // Active duty copy, reloaded at wrap or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_act <= '0;
        else if (load_i)
            duty_act <= duty_pend_i;
    end

    // Compare: high while the counter is below the duty value.
    always_comb pwm_o = enable_i && (cnt_i < duty_act);

    // R9: the active duty only changes when the counter sits at zero.
    p_duty_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_act) |-> cnt_i == '0);
endmodule

// File: rtl/pwm3_shared_period.sv
// Module: pwm3_shared_period (top)
// Three PWM channels that share one period counter. It joins the register
// file, the counter and one comparator per channel, and it combines the
// software pause with the permitted hardware hold.
// Assumes hw_hold and cnt_en are synchronous to clk.
module pwm3_shared_period
    import pwm3_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 14,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hw_hold,
    output logic [NUM_CH-1:0] pwm_out
);
    ctrl_t                        ctrl;
    logic [CNT_W-1:0]             period_pend;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_pend;
    logic [CNT_W-1:0]             cnt;
    logic                         load;
    logic                         paused;

    // Pause source: software bit, or hardware hold when permitted.
    always_comb paused = ctrl.sw_pause || (ctrl.hold_allow && hw_hold);

    pwm3_regs #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ctrl_o(ctrl), .period_o(period_pend), .duty_o(duty_pend)
    );

    pwm3_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .enable_i(ctrl.enable), .pause_i(paused),
        .step_i(cnt_en), .period_pend_i(period_pend), .cnt_o(cnt), .load_o(load)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm3_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .enable_i(ctrl.enable), .load_i(load),
            .duty_pend_i(duty_pend[g]), .cnt_i(cnt), .pwm_o(pwm_out[g])
        );
    end

    // R5, R6: while paused and enabled, the outputs keep their levels.
    p_pause_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.enable && paused) |=> $stable(pwm_out));
    // R7: an unpermitted hold with no software pause lets the counter run.
    p_hold_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.enable && !ctrl.hold_allow && !ctrl.sw_pause && cnt_en && cnt == '0 && period_pend != '0 && load == 1'b0)
        |=> cnt != '0);
endmodule

// File: tb/pwm3_shared_period_bench.sv
module pwm3_shared_period_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        hw_hold = 1'b0;
    logic [2:0]  pwm_out;

    always #4 clk = ~clk;

    pwm3_shared_period u_pwm3_shared_period (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .hw_hold(hw_hold), .pwm_out(pwm_out)
    );

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    string phase = "R1";

    logic [2:0] q_exp[$];
    string      q_tag[$];

    // reference model state
    logic [2:0]  m_ctrl = 3'b100;
    logic [13:0] m_pp = '0, m_pa = '0, m_cnt = '0;
    logic [13:0] m_dp[3] = '{default: '0};
    logic [13:0] m_da[3] = '{default: '0};

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock of stimulus; the model predicts the output after the edge
    task automatic cyc(input logic w, input logic [2:0] a, input logic [15:0] d,
                       input logic tk, input logic hw);
        logic       en, pz;
        logic [2:0] e;
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; cnt_en = tk; hw_hold = hw;
        en = m_ctrl[0];
        pz = m_ctrl[1] | (m_ctrl[2] & hw);
        if (!en) begin
            m_cnt = '0; m_pa = m_pp; m_da = m_dp;
        end else if (!pz && tk) begin
            if (m_cnt == m_pa) begin
                m_cnt = '0; m_pa = m_pp; m_da = m_dp;
            end else m_cnt = m_cnt + 1'b1;
        end
        if (w) begin
            if (a == 3'd0) m_ctrl = d[2:0];
            else if (a == 3'd1) m_pp = d[13:0];
            else if (a >= 3'd2 && a <= 3'd4) m_dp[a-3'd2] = d[13:0];
        end
        for (int i = 0; i < 3; i++) e[i] = m_ctrl[0] && (m_cnt < m_da[i]);
        q_exp.push_back(e);
        q_tag.push_back(phase);
        @(posedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 1'b1, 1'b0);
    endtask

    task automatic run(input int n, input int every, input logic hw);
        for (int k = 0; k < n; k++) cyc(1'b0, 3'd0, 16'd0, (k % every) == 0, hw);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(rd_data === exp, tag, rd_data, exp);
    endtask

    // monitor: compares queued expectations just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [2:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(pwm_out === e, t, pwm_out, e);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(3'd0, 16'h0004, "R1 ctrl");
        rd_chk(3'd1, 16'h0000, "R1 period");
        for (int i = 0; i < 3; i++) rd_chk(3'(2 + i), 16'h0000, "R1 duty");
        check(pwm_out === 3'b000, "R1 outputs", pwm_out, 3'b000);
        // R2 register map and truncation
        phase = "R2";
        wr(3'd1, 16'd9);
        wr(3'd2, 16'd3);
        wr(3'd3, 16'hFFFF);
        rd_chk(3'd3, 16'h3FFF, "R2 duty1 truncated");
        wr(3'd3, 16'd5);
        wr(3'd4, 16'd12);
        wr(3'd0, 16'hFFF8);
        rd_chk(3'd0, 16'h0000, "R2 ctrl truncated");
        rd_chk(3'd1, 16'd9, "R2 period");
        rd_chk(3'd2, 16'd3, "R2 duty0");
        rd_chk(3'd4, 16'd12, "R2 duty2");
        // R3 and R4: dense then sparse strobes
        phase = "R3/R4 dense";
        wr(3'd0, 16'd1);
        run(25, 1, 1'b0);
        phase = "R3 sparse";
        run(40, 3, 1'b0);
        // R5 software pause
        phase = "R5";
        run(4, 1, 1'b0);
        wr(3'd0, 16'd3);
        run(10, 1, 1'b0);
        wr(3'd0, 16'd1);
        run(12, 1, 1'b0);
        // R7 hold ignored without permission
        phase = "R7";
        run(15, 1, 1'b1);
        // R6 hold honored with permission
        phase = "R6";
        wr(3'd0, 16'd5);
        run(3, 1, 1'b0);
        run(10, 1, 1'b1);
        run(10, 1, 1'b0);
        // R9 mid-period updates
        phase = "R9";
        run(4, 1, 1'b0);
        wr(3'd2, 16'd7);
        wr(3'd1, 16'd5);
        run(2, 1, 1'b0);
        wr(3'd3, 16'd0);
        run(20, 1, 1'b0);
        phase = "R9 sparse";
        wr(3'd1, 16'd3);
        run(30, 2, 1'b0);
        // R4 duty 0 low / above period high
        phase = "R4";
        run(12, 1, 1'b0);
        // R8 disable
        phase = "R8";
        wr(3'd0, 16'd4);
        run(6, 1, 1'b0);
        #2;
        check(pwm_out === 3'b000, "R8 outputs low when off", pwm_out, 3'b000);
        phase = "R8 restart";
        wr(3'd0, 16'd1);
        run(12, 1, 1'b0);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule